// File: doc/BRIEF.md
# Overlay Code Phase Search

This block finds where a tracked signal sits within its 10-chip overlay code. Every completed primary-code integration gives one sign bit, presented with a strobe. The block keeps the most recent signs in a 10-bit window. Once a full overlay period has been collected, it compares the window with every cyclic rotation of the code, in both polarities, in the same cycle. A match may come at any alignment, so lock needs at most one overlay period of signs.

On lock the block raises a found flag. It reports the overlay chip that the next integration will use, and whether the signs matched the code directly or inverted. These results stay fixed until the tracking loop pulses the clear input, for example after a loss of lock. The code pattern and the allowed mismatch count are inputs, so the same instance can serve any 10-chip overlay. The usual setting is 0x035 with no mismatches allowed.

Top module: `overlay_phase_search`

## Requirements
- R1: After reset, found_o, phase_o and pol_neg_o are all 0.
- R2: One sign is taken per cycle with strobe_i high, and the newest sign enters window bit 0. When strobe_i is low, sign_i is ignored. Results appear on the outputs in the second clock edge after the strobe cycle.
- R3: No lock occurs until 10 strobes have been accepted since the last reset or clear, even when the signs already fit the code.
- R4: Code bit c (counted from the LSB) is transmitted as chip number 9-c, so chips are sent MSB first. When the last 10 signs equal 10 consecutive chips, starting at any chip of code_i, found_o goes to 1 when err_budget_i is 0.
- R5: phase_o is the chip number, from 0 to 9, that follows the newest matched sign. Internally, rotation r compares window bit i with code bit (i+r) mod 10, and rotation r reports phase (10-r) mod 10.
- R6: If the signs equal the bitwise inverse of the code sequence, the block locks with pol_neg_o = 1. A direct match gives pol_neg_o = 0.
- R7: A candidate matches when its count of differing bits is at most err_budget_i. One mismatch blocks lock at budget 0 and is accepted at budget 1.
- R8: If several candidates match, a positive-polarity candidate is preferred over a negative one. Within the same polarity, the lowest rotation index wins.
- R9: After found_o is set, later strobes do not change found_o, phase_o or pol_neg_o until a clear.
- R10: clear_i returns all outputs to 0, empties the window count, and takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the latest primary-period integration (1 = positive) |
| strobe_i | input | 1 | Accept sign_i this cycle |
| clear_i | input | 1 | Restart the search |
| code_i | input | 10 | Overlay code pattern, chip 0 in the MSB |
| err_budget_i | input | 4 | Largest number of mismatching bits that still counts as a match |
| found_o | output | 1 | Overlay phase has been recovered |
| phase_o | output | 4 | Chip number, from 0 to 9, for the next integration |
| pol_neg_o | output | 1 | 1 when the match was inverted (polarity -1) |

## Verification
Assertions check, on every cycle, the following properties:
- The window loads the newest sign at bit 0.
- The fill count never passes one period.
- A lock appears only on a full window that has a candidate match.
- phase_o stays inside the code length.
- A held lock never drifts.
- A clear always drops the lock.

The following are shown only by the bench scenarios, through the model of the transmitted chip stream in the bench:
- That the reported phase is the correct next chip for each of the ten start alignments.
- That an inverted stream reports polarity -1.
- That the mismatch budget moves the decision in the right direction.
- That the tie-break prefers positive polarity and then the low rotation.

// File: rtl/overlay_pkg.sv
package overlay_pkg;
  localparam int unsigned OVL_LEN  = 10;
  localparam logic [OVL_LEN-1:0] OVL_CODE = 10'h035;

  // Chip number following the newest sign when rotation rot matches.
  function automatic int unsigned phase_after(input int unsigned rot, input int unsigned len);
    return (rot == 0) ? 0 : len - rot;
  endfunction
endpackage

// File: rtl/sign_window.sv
module sign_window #(
  parameter int unsigned LEN = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           shift_i,
  input  logic           sign_i,
  output logic [LEN-1:0] win_o,
  output logic           full_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0]  fill_q;
  logic [LEN-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      win_q <= {win_q[LEN-2:0], sign_i};
      if (!full_o) fill_q <= fill_q + 1'b1;
    end
  end

  assign win_o  = win_q;
  assign full_o = (fill_q == CW'(LEN));

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(LEN)); // R3
  AST_SHIFT_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i && !clear_i |=> win_o[0] == $past(sign_i)); // R2
endmodule

// File: rtl/rotation_matcher.sv
module rotation_matcher #(
  parameter  int unsigned LEN   = 10,
  parameter  int unsigned ERR_W = $clog2(LEN + 1),
  localparam int unsigned RW    = $clog2(LEN)
) (
  input  logic [LEN-1:0]   win_i,
  input  logic [LEN-1:0]   code_i,
  input  logic [ERR_W-1:0] budget_i,
  output logic             hit_o,
  output logic [RW-1:0]    rot_o,
  output logic             neg_o
);
  function automatic logic [LEN-1:0] rotate_code(input logic [LEN-1:0] c, input int unsigned r);
    logic [LEN-1:0] o;
    for (int i = 0; i < int'(LEN); i++) o[i] = c[(i + int'(r)) % int'(LEN)];
    return o;
  endfunction

  function automatic int unsigned count_ones(input logic [LEN-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < int'(LEN); i++) if (v[i]) n++;
    return n;
  endfunction

  logic [LEN-1:0] pos_hit, neg_hit;

  for (genvar r = 0; r < LEN; r++) begin : g_rot
    logic [LEN-1:0] diff;
    assign diff       = win_i ^ rotate_code(code_i, r);
    assign pos_hit[r] = count_ones(diff)  <= 32'(budget_i);
    assign neg_hit[r] = count_ones(~diff) <= 32'(budget_i);
  end

  // Later assignments override: positive beats negative, low rotation beats high.
  always_comb begin
    hit_o = 1'b0;
    rot_o = '0;
    neg_o = 1'b0;
    for (int r = int'(LEN) - 1; r >= 0; r--) begin
      if (neg_hit[r]) begin
        hit_o = 1'b1; rot_o = RW'(r); neg_o = 1'b1;
      end
    end
    for (int r = int'(LEN) - 1; r >= 0; r--) begin
      if (pos_hit[r]) begin
        hit_o = 1'b1; rot_o = RW'(r); neg_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
  parameter  int unsigned LEN  = 10,
  localparam int unsigned RW   = $clog2(LEN),
  localparam int unsigned PH_W = $clog2(LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            shift_i,
  input  logic            full_i,
  input  logic            hit_i,
  input  logic [RW-1:0]   rot_i,
  input  logic            neg_i,
  output logic            lock_evt_o,
  output logic            found_o,
  output logic [PH_W-1:0] phase_o,
  output logic            neg_o
);
  logic eval_q;

  assign lock_evt_o = eval_q && full_i && hit_i && !found_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q  <= 1'b0;
      found_o <= 1'b0;
      phase_o <= '0;
      neg_o   <= 1'b0;
    end else if (clear_i) begin
      eval_q  <= 1'b0;
      found_o <= 1'b0;
      phase_o <= '0;
      neg_o   <= 1'b0;
    end else begin
      eval_q <= shift_i;
      if (lock_evt_o) begin
        found_o <= 1'b1;
        phase_o <= PH_W'(overlay_pkg::phase_after(32'(rot_i), LEN));
        neg_o   <= neg_i;
      end
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    found_o && !clear_i |=> found_o && $stable(phase_o) && $stable(neg_o)); // R9
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !found_o && phase_o == '0 && !neg_o); // R10
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o < PH_W'(LEN)); // R5
endmodule

// File: rtl/overlay_phase_search.sv
module overlay_phase_search #(
  parameter  int unsigned LEN   = overlay_pkg::OVL_LEN,
  localparam int unsigned ERR_W = $clog2(LEN + 1),
  localparam int unsigned PH_W  = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sign_i,
  input  logic             strobe_i,
  input  logic             clear_i,
  input  logic [LEN-1:0]   code_i,
  input  logic [ERR_W-1:0] err_budget_i,
  output logic             found_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             pol_neg_o
);
  logic [LEN-1:0]  win;
  logic            win_full;
  logic            any_hit;
  logic [PH_W-1:0] best_rot;
  logic            best_neg;
  logic            lock_evt;

  sign_window #(.LEN(LEN)) u_window (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .shift_i(strobe_i),
    .sign_i(sign_i), .win_o(win), .full_o(win_full)
  );

  rotation_matcher #(.LEN(LEN), .ERR_W(ERR_W)) u_match (
    .win_i(win), .code_i(code_i), .budget_i(err_budget_i),
    .hit_o(any_hit), .rot_o(best_rot), .neg_o(best_neg)
  );

  lock_ctrl #(.LEN(LEN)) u_lock (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .shift_i(strobe_i),
    .full_i(win_full), .hit_i(any_hit), .rot_i(best_rot), .neg_i(best_neg),
    .lock_evt_o(lock_evt), .found_o(found_o), .phase_o(phase_o), .neg_o(pol_neg_o)
  );

  AST_NO_EARLY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_o) |-> $past(win_full)); // R3
  AST_LOCK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_o) |-> $past(any_hit) && $past(lock_evt)); // R4
endmodule

// File: tb/overlay_phase_search_tb.sv
`timescale 1ns/1ps
module overlay_phase_search_tb;
  localparam int L = 10;
  localparam logic [L-1:0] CODE = 10'h035;

  logic clk = 1'b0, rst_n = 1'b0, sign_i = 1'b0, strobe_i = 1'b0, clear_i = 1'b0;
  logic [L-1:0] code_i = CODE;
  logic [3:0]   err_budget_i = '0;
  logic         found_o, pol_neg_o;
  logic [3:0]   phase_o;

  always #4 clk = ~clk;

  overlay_phase_search u_dut (
    .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .strobe_i(strobe_i), .clear_i(clear_i),
    .code_i(code_i), .err_budget_i(err_budget_i),
    .found_o(found_o), .phase_o(phase_o), .pol_neg_o(pol_neg_o)
  );

  int checks = 0, errors = 0;
  int hist[L];
  int m_fill = 0, m_phase = 0;
  bit m_found = 0, m_neg = 0;

  // Value of transmitted chip t (MSB of the code is chip 0).
  function automatic int chip_at(input int t);
    int k = ((t % L) + L) % L;
    return int'(CODE[L-1-k]);
  endfunction

  function automatic void model_search(input int budget, output bit hit, output int ph, output bit neg);
    hit = 0; ph = 0; neg = 0;
    for (int pol = 0; pol < 2 && !hit; pol++) begin
      for (int r = 0; r < L && !hit; r++) begin
        int p = (L - r) % L;
        int bad = 0;
        for (int j = 0; j < L; j++) if (hist[j] != (chip_at(p - L + j) ^ pol)) bad++;
        if (bad <= budget) begin hit = 1; ph = p; neg = (pol == 1); end
      end
    end
  endfunction

  function automatic void model_push(input int s, input int budget);
    bit h; int ph; bit ng;
    for (int j = 0; j < L - 1; j++) hist[j] = hist[j+1];
    hist[L-1] = s;
    if (m_fill < L) m_fill++;
    if (m_fill == L && !m_found) begin
      model_search(budget, h, ph, ng);
      if (h) begin m_found = 1; m_phase = ph; m_neg = ng; end
    end
  endfunction

  function automatic void model_clear();
    for (int j = 0; j < L; j++) hist[j] = 0;
    m_fill = 0; m_found = 0; m_phase = 0; m_neg = 0;
  endfunction

  task automatic push(input int s);
    @(negedge clk); sign_i = s[0]; strobe_i = 1'b1;
    @(negedge clk); strobe_i = 1'b0; sign_i = ~sign_i;
    @(negedge clk);
    model_push(s, int'(err_budget_i));
  endtask

  task automatic do_clear();
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    model_clear();
  endtask

  task automatic check_out(input string req);
    checks++;
    if (found_o !== m_found || phase_o !== 4'(m_phase) || pol_neg_o !== m_neg) begin
      errors++;
      $display("FAIL %s: found=%0b phase=%0d neg=%0b expected found=%0b phase=%0d neg=%0b",
               req, found_o, phase_o, pol_neg_o, m_found, m_phase, m_neg);
    end
  endtask

  task automatic check_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 reset state");

    // R3/R4/R5/R6: every start alignment, random polarity, then hold (R9)
    for (int s0 = 0; s0 < L; s0++) begin
      int pol = int'($urandom_range(0, 1));
      err_budget_i = 0;
      do_clear();
      for (int k = 0; k < L; k++) begin
        push(chip_at(s0 + k) ^ pol);
        if (k == L - 2) check_out("R3 no lock before full period");
      end
      check_out("R4 lock at any alignment");
      check_val("R5 next chip phase", int'(phase_o), s0);
      check_val("R6 polarity", int'(pol_neg_o), pol);
      for (int k = 0; k < 4; k++) push(int'($urandom_range(0, 1)));
      check_out("R9 lock held after later strobes");
    end

    // R7: one flipped chip at budget 0 then budget 1
    for (int b = 0; b < 2; b++) begin
      err_budget_i = 4'(b);
      do_clear();
      for (int k = 0; k < L; k++) push(chip_at(3 + k) ^ (k == 4 ? 1 : 0));
      check_out("R7 mismatch budget");
      check_val("R7 found vs budget", int'(found_o), b);
    end

    // R8: budget admits every candidate -> rotation 0, positive
    err_budget_i = 4'd10;
    do_clear();
    for (int k = 0; k < L; k++) push(int'($urandom_range(0, 1)));
    check_out("R8 priority");
    check_val("R8 phase of rotation 0", int'(phase_o), 0);
    check_val("R8 positive preferred", int'(pol_neg_o), 0);

    // R10: clear with simultaneous strobe while locked
    err_budget_i = 0;
    @(negedge clk); clear_i = 1'b1; strobe_i = 1'b1; sign_i = 1'b1;
    @(negedge clk); clear_i = 1'b0; strobe_i = 1'b0;
    @(negedge clk);
    model_clear();
    check_out("R10 clear wins");
    for (int k = 0; k < L - 1; k++) push(chip_at(k));
    check_out("R10 fill count restarted");
    push(chip_at(L - 1));
    check_out("R10 relock after clear");

    // R2: sign toggling without strobe is ignored
    do_clear();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); sign_i = k[0];
    end
    for (int k = 0; k < L - 1; k++) push(chip_at(7 + k) ^ 1);
    check_out("R2 unstrobed signs ignored");
    push(chip_at(7 + L - 1) ^ 1);
    check_out("R2 lock after ten strobes");

    // Random rounds: mixed code streams, noise and budgets
    for (int rnd = 0; rnd < 40; rnd++) begin
      int s0 = int'($urandom_range(0, L - 1));
      int pol = int'($urandom_range(0, 1));
      bit coded = (rnd % 2 == 0);
      err_budget_i = 4'($urandom_range(0, 2));
      do_clear();
      for (int k = 0; k < 12; k++) begin
        int s;
        if (coded) s = chip_at(s0 + k) ^ pol ^ ($urandom_range(0, 7) == 0 ? 1 : 0);
        else       s = int'($urandom_range(0, 1));
        push(s);
        check_out("R7 random stream");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule